// File: doc/BRIEF.md
# USB OUT Endpoint Packet Buffer

This block is the receive side of one non-control USB endpoint as a CPU bus sees it. The USB side streams the bytes of a packet into a byte store and then strobes end-of-packet for a good packet. That strobe commits the packet. The block then raises a packet-ready flag and exposes the received byte count through two count registers. The CPU drains the packet one byte per read of a data port. It hands the storage back either by writing 0 to the ready flag or, when auto-clear is enabled, automatically once a maximum-size packet has been fully read.

The endpoint can run in two buffering modes. With a single buffer, the USB side is refused until the CPU releases the pending packet. With ping-pong buffering, a second packet can land while the CPU drains the first, and the ready flag and count then move on to it at release. When no buffer is free, the block raises a refuse signal (the equivalent of a NAK) and ignores bytes and end-of-packet strobes, so stored data is never overwritten. A type bit selects bulk/interrupt (0) or isochronous (1) transfers. Software reads the bit back, and it does not change how the buffers behave.

Top module: `usb_out_ep_buf`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00, both count registers read 0, and `usb_nak_o` is 0.
- R2: One cycle after an accepted end-of-packet strobe, control bit 0 (packet ready) reads 1. The count low register (address 1) then holds count bits 7:0, and the count high register (address 2) holds count bits 10:8 in bits 2:0 with bits 7:3 reading 0.
- R3: Each read of the data port (address 5) while ready returns the next stored byte of the current packet, in arrival order, starting at the first byte.
- R4: A write to the control register with bit 0 = 0 while ready releases the packet. A write with bit 0 = 1 leaves the ready flag unchanged.
- R5: With auto-clear (control bit 3) set, reading the last byte of a packet whose length equals the maximum packet size clears the ready flag. A shorter packet stays ready after all of its bytes are read.
- R6: With double buffering off (control bit 1 = 0), a pending packet asserts `usb_nak_o`. Further bytes and end-of-packet strobes are then ignored, and the pending count and data remain unchanged.
- R7: With double buffering on, a second packet is accepted while the first is pending, and a third is refused. After the first is released, the ready flag stays 1, and the count and data switch to the second packet.
- R8: A data port read while not ready returns 0 and does not advance the read position.
- R9: Control bits 1 (double buffer), 2 (type, 0 = bulk/interrupt, 1 = isochronous) and 3 (auto-clear) read back as written. Bits 7:4 always read 0.
- R10: The 11-bit maximum packet size is written and read as a low register (address 3, bits 7:0) and a high register (address 4, bits 10:8 in bits 2:0). Bits 7:3 of the high register read 0.
- R11: Both count registers read 0 while the ready flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| usb_wr_i | input | 1 | USB side byte strobe |
| usb_data_i | input | 8 | USB side byte |
| usb_eop_i | input | 1 | USB side end of good packet, commits the packet |
| usb_nak_o | output | 1 | No free buffer; USB input is ignored |
| cpu_sel_i | input | 3 | CPU register address |
| cpu_rd_i | input | 1 | CPU read strobe |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | CPU read data (combinational on address) |

## Verification
A wrong read pointer shows on the data port at once: the next read returns a byte out of order or a stale value. A wrong buffer-full or bank-select bit shows on the ready flag, the count registers or `usb_nak_o` in the cycle after the commit or release that disturbed it. A lost packet or an overwrite shows as a count that changes without a release. Wrong auto-clear logic shows as a ready flag that drops early, drops for a short packet, or stays up after the final byte of a maximum-size packet.

// File: rtl/usb_out_ep_pkg.sv
package usb_out_ep_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_CNT_LO = 3'd1,
    REG_CNT_HI = 3'd2,
    REG_MAX_LO = 3'd3,
    REG_MAX_HI = 3'd4,
    REG_DATA   = 3'd5
  } reg_addr_e;

  localparam int CTRL_RDY  = 0;
  localparam int CTRL_DBL  = 1;
  localparam int CTRL_ISO  = 2;
  localparam int CTRL_ACLR = 3;
endpackage

// File: rtl/usb_out_ep_bank.sv
module usb_out_ep_bank #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/usb_out_ep_ctrl.sv
module usb_out_ep_ctrl #(
  parameter int DEPTH = 512,
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             usb_wr_i,
  input  logic [7:0]       usb_data_i,
  input  logic             usb_eop_i,
  output logic             usb_nak_o,
  input  logic             pop_i,
  input  logic             release_i,
  input  logic             dbl_en_i,
  input  logic             auto_clr_i,
  input  logic [CNT_W-1:0] max_pkt_i,
  output logic             pkt_rdy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [7:0]       pop_data_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [1:0]       full_q;
  logic             fill_q, rd_q;
  logic [CNT_W-1:0] wcnt_q, rptr_q;
  logic [CNT_W-1:0] len_q [2];
  logic [7:0]       bank_rd [2];
  logic             wr_acc, commit, pop_ok, auto_hit, rel;

  assign usb_nak_o = full_q[fill_q];
  assign pkt_rdy_o = full_q[rd_q];
  assign cnt_o     = len_q[rd_q];

  assign wr_acc   = usb_wr_i && !usb_nak_o && (wcnt_q < DEPTH_C);
  assign commit   = usb_eop_i && !usb_nak_o;
  assign pop_ok   = pop_i && pkt_rdy_o && (rptr_q < cnt_o);
  assign auto_hit = pop_ok && auto_clr_i && (rptr_q + CNT_W'(1) == cnt_o) && (cnt_o == max_pkt_i);
  assign rel      = (release_i && pkt_rdy_o) || auto_hit;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    usb_out_ep_bank #(.DEPTH(DEPTH), .AW(AW)) u_bank (
      .clk_i   (clk_i),
      .we_i    (wr_acc && (fill_q == 1'(b))),
      .waddr_i (wcnt_q[AW-1:0]),
      .wdata_i (usb_data_i),
      .raddr_i (rptr_q[AW-1:0]),
      .rdata_o (bank_rd[b])
    );
  end

  assign pop_data_o = pop_ok ? bank_rd[rd_q] : 8'h00;

  // fill side and drain side never touch the same bank in one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= '0;
      fill_q <= 1'b0;
      rd_q   <= 1'b0;
      wcnt_q <= '0;
      rptr_q <= '0;
      for (int b = 0; b < 2; b++) len_q[b] <= '0;
    end else begin
      if (commit) begin
        full_q[fill_q] <= 1'b1;
        len_q[fill_q]  <= wcnt_q + CNT_W'(wr_acc);
        wcnt_q         <= '0;
        if (dbl_en_i) fill_q <= ~fill_q;
      end else if (wr_acc) begin
        wcnt_q <= wcnt_q + CNT_W'(1);
      end
      if (rel) begin
        full_q[rd_q] <= 1'b0;
        rptr_q       <= '0;
        if (dbl_en_i) rd_q <= ~rd_q;
      end else if (pop_ok) begin
        rptr_q <= rptr_q + CNT_W'(1);
      end
    end
  end

  AST_NAK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usb_nak_o && !rel |=> usb_nak_o); // R6
  AST_PKT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_rdy_o && !rel |=> pkt_rdy_o && $stable(cnt_o)); // R6
  AST_RPTR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_rdy_o |-> rptr_q <= cnt_o); // R3
  AST_AUTO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_hit && !dbl_en_i |=> !pkt_rdy_o); // R5
endmodule

// File: rtl/usb_out_ep_csr.sv
module usb_out_ep_csr
  import usb_out_ep_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic              pkt_rdy_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [7:0]        pop_data_i,
  output logic              pop_o,
  output logic              release_o,
  output logic              dbl_en_o,
  output logic              auto_clr_o,
  output logic [CNT_W-1:0]  max_pkt_o,
  output logic [7:0]        rdata_o
);
  logic iso_q, dbl_q, aclr_q;
  logic [CNT_W-1:0] max_q;
  logic ctrl_wr;

  assign ctrl_wr    = wr_i && (sel_i == REG_CTRL);
  assign release_o  = ctrl_wr && !wdata_i[CTRL_RDY];
  assign pop_o      = rd_i && (sel_i == REG_DATA);
  assign dbl_en_o   = dbl_q;
  assign auto_clr_o = aclr_q;
  assign max_pkt_o  = max_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iso_q  <= 1'b0;
      dbl_q  <= 1'b0;
      aclr_q <= 1'b0;
      max_q  <= '0;
    end else if (wr_i) begin
      case (sel_i)
        REG_CTRL: begin
          dbl_q  <= wdata_i[CTRL_DBL];
          iso_q  <= wdata_i[CTRL_ISO];
          aclr_q <= wdata_i[CTRL_ACLR];
        end
        REG_MAX_LO: max_q[7:0]       <= wdata_i;
        REG_MAX_HI: max_q[CNT_W-1:8] <= wdata_i[CNT_W-9:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    case (sel_i)
      REG_CTRL:   rdata_o = {4'b0000, aclr_q, iso_q, dbl_q, pkt_rdy_i};
      REG_CNT_LO: rdata_o = pkt_rdy_i ? cnt_i[7:0] : 8'h00;
      REG_CNT_HI: rdata_o = pkt_rdy_i ? 8'(cnt_i[CNT_W-1:8]) : 8'h00;
      REG_MAX_LO: rdata_o = max_q[7:0];
      REG_MAX_HI: rdata_o = 8'(max_q[CNT_W-1:8]);
      REG_DATA:   rdata_o = pop_data_i;
      default:    rdata_o = 8'h00;
    endcase
  end

  AST_MAX_LO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && sel_i == REG_MAX_LO |=> max_q[7:0] == $past(wdata_i)); // R10
  AST_CFG_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && sel_i == REG_CTRL) |=> $stable({aclr_q, iso_q, dbl_q})); // R9
endmodule

// File: rtl/usb_out_ep_buf.sv
module usb_out_ep_buf
  import usb_out_ep_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int CNT_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              usb_wr_i,
  input  logic [7:0]        usb_data_i,
  input  logic              usb_eop_i,
  output logic              usb_nak_o,
  input  logic [ADDR_W-1:0] cpu_sel_i,
  input  logic              cpu_rd_i,
  input  logic              cpu_wr_i,
  input  logic [7:0]        cpu_wdata_i,
  output logic [7:0]        cpu_rdata_o
);
  logic             pop, rel_req, dbl_en, auto_clr, pkt_rdy;
  logic [CNT_W-1:0] max_pkt, cnt;
  logic [7:0]       pop_data;

  usb_out_ep_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .usb_wr_i   (usb_wr_i),
    .usb_data_i (usb_data_i),
    .usb_eop_i  (usb_eop_i),
    .usb_nak_o  (usb_nak_o),
    .pop_i      (pop),
    .release_i  (rel_req),
    .dbl_en_i   (dbl_en),
    .auto_clr_i (auto_clr),
    .max_pkt_i  (max_pkt),
    .pkt_rdy_o  (pkt_rdy),
    .cnt_o      (cnt),
    .pop_data_o (pop_data)
  );

  usb_out_ep_csr #(.CNT_W(CNT_W)) u_csr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (cpu_sel_i),
    .rd_i       (cpu_rd_i),
    .wr_i       (cpu_wr_i),
    .wdata_i    (cpu_wdata_i),
    .pkt_rdy_i  (pkt_rdy),
    .cnt_i      (cnt),
    .pop_data_i (pop_data),
    .pop_o      (pop),
    .release_o  (rel_req),
    .dbl_en_o   (dbl_en),
    .auto_clr_o (auto_clr),
    .max_pkt_o  (max_pkt),
    .rdata_o    (cpu_rdata_o)
  );

  AST_IDLE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rd_i && cpu_sel_i == REG_DATA && !pkt_rdy |-> cpu_rdata_o == 8'h00); // R8
endmodule

// File: tb/tb_usb_out_ep_buf.sv
module tb_usb_out_ep_buf;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       usb_wr_i = 1'b0;
  logic [7:0] usb_data_i = 8'h00;
  logic       usb_eop_i = 1'b0;
  logic       usb_nak_o;
  logic [2:0] cpu_sel_i = 3'd0;
  logic       cpu_rd_i = 1'b0;
  logic       cpu_wr_i = 1'b0;
  logic [7:0] cpu_wdata_i = 8'h00;
  logic [7:0] cpu_rdata_o;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  localparam logic [2:0] A_CTRL = 3'd0, A_CNTL = 3'd1, A_CNTH = 3'd2,
                         A_MAXL = 3'd3, A_MAXH = 3'd4, A_DATA = 3'd5;

  usb_out_ep_buf dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cpu_sel_i = a; cpu_wdata_i = d; cpu_wr_i = 1'b1;
    @(negedge clk_i);
    cpu_wr_i = 1'b0;
  endtask

  task automatic cpu_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i);
    cpu_sel_i = a; cpu_rd_i = 1'b1;
    #1 d = cpu_rdata_o;
    @(negedge clk_i);
    cpu_rd_i = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i);
    cpu_sel_i = a;
    #1 d = cpu_rdata_o;
  endtask

  task automatic usb_send(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      usb_wr_i = 1'b1; usb_data_i = base + 8'(i);
    end
    @(negedge clk_i);
    usb_wr_i = 1'b0; usb_eop_i = 1'b1;
    @(negedge clk_i);
    usb_eop_i = 1'b0;
  endtask

  task automatic get_cnt(output int c);
    logic [7:0] lo, hi;
    peek(A_CNTL, lo);
    peek(A_CNTH, hi);
    c = {hi, lo};
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek(A_CTRL, v); chk("R1 ctrl", v, 8'h00);
    peek(A_CNTL, v); chk("R1 cnt_lo", v, 8'h00);
    peek(A_CNTH, v); chk("R1 cnt_hi", v, 8'h00);
    chk("R1 nak", usb_nak_o, 0);
  endtask

  task automatic t_config();
    logic [7:0] v;
    cpu_write(A_CTRL, 8'hFE);
    peek(A_CTRL, v); chk("R9 ctrl readback", v, 8'h0E);
    cpu_write(A_CTRL, 8'h05);
    peek(A_CTRL, v); chk("R9 iso only, rdy stays 0", v, 8'h04);
    cpu_write(A_MAXL, 8'h34);
    cpu_write(A_MAXH, 8'hFD);
    peek(A_MAXL, v); chk("R10 max lo", v, 8'h34);
    peek(A_MAXH, v); chk("R10 max hi", v, 8'h05);
    cpu_write(A_CTRL, 8'h00);
  endtask

  task automatic t_single();
    logic [7:0] v;
    int c;
    get_cnt(c); chk("R11 idle count", c, 0);
    usb_send(5, 8'h10);
    peek(A_CTRL, v); chk("R2 ready", v, 8'h01);
    get_cnt(c); chk("R2 count", c, 5);
    chk("R6 nak pending", usb_nak_o, 1);
    usb_send(3, 8'h80);
    cpu_read(A_DATA, v); chk("R3 byte0", v, 8'h10);
    cpu_read(A_DATA, v); chk("R3 byte1", v, 8'h11);
    get_cnt(c); chk("R6 count kept", c, 5);
    cpu_read(A_DATA, v); chk("R6 data kept", v, 8'h12);
    cpu_write(A_CTRL, 8'h01);
    peek(A_CTRL, v); chk("R4 write 1 keeps ready", v, 8'h01);
    cpu_write(A_CTRL, 8'h00);
    peek(A_CTRL, v); chk("R4 release", v, 8'h00);
    chk("R4 nak after release", usb_nak_o, 0);
    get_cnt(c); chk("R11 count after release", c, 0);
    cpu_read(A_DATA, v); chk("R8 idle read zero", v, 8'h00);
    usb_send(3, 8'h40);
    cpu_read(A_DATA, v); chk("R8 no advance", v, 8'h40);
    cpu_write(A_CTRL, 8'h00);
  endtask

  task automatic t_big();
    logic [7:0] v;
    int c, bad;
    usb_send(300, 8'h00);
    peek(A_CNTL, v); chk("R2 cnt lo 300", v, 8'h2C);
    peek(A_CNTH, v); chk("R2 cnt hi 300", v, 8'h01);
    get_cnt(c);
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      cpu_read(A_DATA, v);
      if (v != 8'(i)) bad++;
    end
    chk("R3 300 bytes in order, mismatches", bad, 0);
    cpu_write(A_CTRL, 8'h00);
  endtask

  task automatic t_autoclr();
    logic [7:0] v;
    cpu_write(A_MAXL, 8'h04);
    cpu_write(A_MAXH, 8'h00);
    cpu_write(A_CTRL, 8'h09);
    usb_send(4, 8'h60);
    for (int i = 0; i < 3; i++) cpu_read(A_DATA, v);
    peek(A_CTRL, v); chk("R5 ready before last", v, 8'h09);
    cpu_read(A_DATA, v); chk("R5 last byte", v, 8'h63);
    peek(A_CTRL, v); chk("R5 auto clear", v, 8'h08);
    usb_send(3, 8'h70);
    for (int i = 0; i < 3; i++) cpu_read(A_DATA, v);
    peek(A_CTRL, v); chk("R5 short pkt stays ready", v, 8'h09);
    cpu_write(A_CTRL, 8'h08);
    peek(A_CTRL, v); chk("R4 release in auto mode", v, 8'h08);
    cpu_write(A_CTRL, 8'h00);
  endtask

  task automatic t_double();
    logic [7:0] v;
    int c;
    cpu_write(A_CTRL, 8'h03);
    usb_send(4, 8'hA0);
    chk("R7 nak after first", usb_nak_o, 0);
    usb_send(6, 8'hB0);
    chk("R7 nak after second", usb_nak_o, 1);
    usb_send(2, 8'hC0);
    get_cnt(c); chk("R7 first count", c, 4);
    cpu_read(A_DATA, v); chk("R7 first data", v, 8'hA0);
    cpu_write(A_CTRL, 8'h02);
    peek(A_CTRL, v); chk("R7 still ready", v, 8'h03);
    get_cnt(c); chk("R7 second count", c, 6);
    cpu_read(A_DATA, v); chk("R7 second data", v, 8'hB0);
    chk("R7 buffer freed", usb_nak_o, 0);
    cpu_write(A_CTRL, 8'h02);
    peek(A_CTRL, v); chk("R7 both drained", v, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_config();
    t_single();
    t_big();
    t_autoclr();
    t_double();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule